// File: doc/BRIEF.md
# SPI Master with Per-Word Chip-Select Hold

This block is a single-line SPI master driven by a small register port. Software programs a prescale value and two chip-select delay counts, then launches each 8-bit character by writing the transmit register. The character goes out most significant bit first, in mode 0 timing: the serial clock idles low, the slave samples on the rising edge and output data moves on the falling edge. The byte clocked in from the slave lands in a receive register that also reports whether the transmit buffer is still occupied.

Every transmit word carries its own keep-select bit. When that bit is set, chip select stays asserted after the word. If the next word is already waiting, it follows straight on with no setup delay. If nothing is waiting, chip select stays low until software writes again. When the keep-select bit is clear, chip select is released after the programmed tail delay. A multi-byte transaction is therefore a run of writes in which only the last word has the bit clear.

A control register holds a soft-reset bit, a run-enable bit and the level of the chip-select pin while no frame is active. After reset the soft-reset bit is set and run-enable is clear, so software must clear soft reset and set run-enable before any word is sent.

Top module: `spi_cs_hold_master`

## Requirements
- R1: After the synchronous active-low reset, cs_n is 1 and sclk is 0. The receive register (address 3) reads rx-empty (bit 8) as 1 and tx-full (bit 9) as 0.
- R2: Control bit 1 (soft reset) is 1 after reset. While it is set, writes to the transmit register (address 2) are ignored. Setting it also drops a pending word (tx-full returns to 0), returns the engine to idle and sets rx-empty.
- R3: Control bit 0 (run-enable) gates the start of words. A word written while it is 0 stays pending, with tx-full at 1 and chip select inactive, until the bit is set.
- R4: Each word shifts 8 bits MSB first in mode 0. sclk idles low, mosi changes only on falling edges, and miso is sampled before each falling edge. When the word ends, the sampled byte appears in receive bits [7:0].
- R5: Timing bits [7:0] hold the prescale value P. One bit lasts P+1 clock cycles (a P of 0 is treated as 1), and sclk is low for the first floor((P+1)/2) cycles of each bit.
- R6: Timing bits [15:8] hold the setup count S. From the cycle in which chip select asserts to the first rising sclk edge there are S+1+floor((P+1)/2) cycles.
- R7: Timing bits [23:16] hold the tail count H. For a word with the keep-select bit clear, chip select deasserts H+1 cycles after the last falling sclk edge.
- R8: Transmit bit 8 is the keep-select bit. If it is set and a word is pending when the word ends, the next word's first rising edge follows floor((P+1)/2) cycles after the last falling edge, with no setup delay. If no word is pending, chip select stays asserted with sclk low until the next accepted write.
- R9: Transmit bits [7:0] are the data. A write that is accepted sets tx-full until the engine takes the word. A write while tx-full is 1 is ignored and transmits nothing.
- R10: Reading address 3 returns {tx-full, rx-empty, byte} in bits [9:0] and sets rx-empty. A newly completed byte overwrites an unread one. If a byte completes in the same cycle as a read, the new byte stays readable.
- R11: Control bit 2 (reset value 1) is the level driven on cs_n while no frame is active. The active level is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (consumes the receive byte at address 3) |
| reg_addr | input | 2 | Register address: 0 control, 1 timing, 2 transmit, 3 receive/status |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 24 | Read data, valid in the cycle of the read |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | 1 | Chip select, active low |

## Verification
The collision that matters is a received byte landing in the receive register in the same cycle that a read consumes the register. The bench sends one word and then holds the read strobe high on every cycle until chip select has risen, so some read must coincide with the completion edge. It then counts how many sampled reads showed rx-empty at 0. Exactly one such read, carrying the slave's byte, is correct. Zero reads means the consume won over the arriving byte.

// File: rtl/spi_chm_pkg.sv
// Package: shared state encoding and register addresses for the SPI master.
// Assumes a 2-bit register address; all widths live in module parameters.
package spi_chm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_HELD,
        ST_TAIL
    } eng_state_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_TIME = 2'd1;
    localparam logic [1:0] ADDR_TX   = 2'd2;
    localparam logic [1:0] ADDR_RX   = 2'd3;

endpackage

// File: rtl/spi_chm_regs.sv
// Register file: control, timing, single transmit buffer and receive byte.
// Assumes take is only raised while tx_full is set; reads are combinational.
module spi_chm_regs
    import spi_chm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PRE_W  = 8,
    parameter int DLY_W  = 8,
    parameter int REG_W  = PRE_W + 2 * DLY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              run_en,
    output logic              soft_rst,
    output logic              cs_idle,
    output logic [PRE_W-1:0]  prescale,
    output logic [DLY_W-1:0]  setup_dly,
    output logic [DLY_W-1:0]  hold_dly,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_keep,
    output logic              tx_full,
    input  logic              take,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              rx_empty
);

    localparam int STAT_W = DATA_W + 2;

    logic [DATA_W-1:0] rx_data;
    logic              wr_ctrl, wr_time, wr_tx, rd_rx;

    assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_time = reg_wr && (reg_addr == ADDR_TIME);
    assign wr_tx   = reg_wr && (reg_addr == ADDR_TX);
    assign rd_rx   = reg_rd && (reg_addr == ADDR_RX);

    // Control bits: soft reset, run enable, idle chip-select level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en   <= 1'b0;
            soft_rst <= 1'b1;
            cs_idle  <= 1'b1;
        end else if (wr_ctrl) begin
            run_en   <= reg_wdata[0];
            soft_rst <= reg_wdata[1];
            cs_idle  <= reg_wdata[2];
        end
    end

    // Timing fields: prescale, setup count and tail count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prescale  <= '0;
            setup_dly <= '0;
            hold_dly  <= '0;
        end else if (wr_time) begin
            prescale  <= reg_wdata[PRE_W-1:0];
            setup_dly <= reg_wdata[PRE_W+DLY_W-1:PRE_W];
            hold_dly  <= reg_wdata[PRE_W+2*DLY_W-1:PRE_W+DLY_W];
        end
    end

    // Single transmit buffer: accept only when empty, free on take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_full <= 1'b0;
            tx_data <= '0;
            tx_keep <= 1'b0;
        end else if (soft_rst) begin
            tx_full <= 1'b0;
        end else if (take) begin
            tx_full <= 1'b0;
        end else if (wr_tx && !tx_full) begin
            tx_full <= 1'b1;
            tx_data <= reg_wdata[DATA_W-1:0];
            tx_keep <= reg_wdata[DATA_W];
        end
    end

    // Receive byte: a new byte wins over a read in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_empty <= 1'b1;
            rx_data  <= '0;
        end else if (soft_rst) begin
            rx_empty <= 1'b1;
        end else if (rx_valid) begin
            rx_empty <= 1'b0;
            rx_data  <= rx_byte;
        end else if (rd_rx) begin
            rx_empty <= 1'b1;
        end
    end

    // Read mux: only the receive/status address returns data.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_RX) begin
            reg_rdata = REG_W'({tx_full, rx_empty, rx_data});
        end
    end

    logic [STAT_W-1:0] unused_stat_w;
    assign unused_stat_w = '0;

endmodule

// File: rtl/spi_chm_bittimer.sv
// Bit timer: divides the module clock into bit periods of prescale+1 cycles.
// Assumes run stays high for a whole run of bits; counter clears when idle.
module spi_chm_bittimer #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] prescale,
    output logic             sclk_hi,
    output logic             bit_end
);

    logic [PRE_W-1:0] pc;
    logic [PRE_W-1:0] top_v;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] low_len;

    assign top_v   = (prescale == '0) ? PRE_W'(1) : prescale;
    assign span    = {1'b0, top_v} + (PRE_W + 1)'(1);
    assign low_len = PRE_W'(span >> 1);

    // Phase counter within one bit, wrapping at the prescale limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pc <= '0;
        end else if (pc == top_v) begin
            pc <= '0;
        end else begin
            pc <= pc + PRE_W'(1);
        end
    end

    assign sclk_hi = run && (pc >= low_len);
    assign bit_end = run && (pc == top_v);

endmodule

// File: rtl/spi_chm_engine.sv
// Frame engine: chip-select sequencing, setup/tail delays and the shifter.
// Assumes bit_end comes from a timer that runs only in the shift state.
module spi_chm_engine
    import spi_chm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DLY_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              run_en,
    input  logic [DLY_W-1:0]  setup_dly,
    input  logic [DLY_W-1:0]  hold_dly,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_keep,
    input  logic              tx_full,
    output logic              take,
    output logic              bit_run,
    input  logic              bit_end,
    input  logic              miso,
    output logic              cs_act,
    output logic              mosi,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_byte
);

    localparam int BIT_CW = $clog2(DATA_W);

    eng_state_t        state;
    logic [DLY_W-1:0]  cnt;
    logic [BIT_CW-1:0] bitcnt;
    logic [DATA_W-1:0] sh;
    logic              keep;
    logic              last_bit;
    logic              word_done;

    assign last_bit  = (bitcnt == BIT_CW'(DATA_W - 1));
    assign word_done = (state == ST_SHIFT) && bit_end && last_bit;

    // Word pickup: from idle, from a held select, or chained at word end.
    always_comb begin
        take = 1'b0;
        if (!soft_rst && run_en && tx_full) begin
            take = (state == ST_IDLE) || (state == ST_HELD) ||
                   (word_done && keep);
        end
    end

    // Sequencer: setup delay, shifting, hold/chain decision, tail delay.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            bitcnt <= '0;
            sh     <= '0;
            keep   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (take) begin
                        sh    <= tx_data;
                        keep  <= tx_keep;
                        cnt   <= '0;
                        state <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (cnt == setup_dly) begin
                        state  <= ST_SHIFT;
                        bitcnt <= '0;
                    end else begin
                        cnt <= cnt + DLY_W'(1);
                    end
                end
                ST_SHIFT: begin
                    if (bit_end) begin
                        if (last_bit) begin
                            bitcnt <= '0;
                            if (!keep) begin
                                sh    <= {sh[DATA_W-2:0], miso};
                                cnt   <= '0;
                                state <= ST_TAIL;
                            end else if (take) begin
                                sh   <= tx_data;
                                keep <= tx_keep;
                            end else begin
                                sh    <= {sh[DATA_W-2:0], miso};
                                state <= ST_HELD;
                            end
                        end else begin
                            bitcnt <= bitcnt + BIT_CW'(1);
                            sh     <= {sh[DATA_W-2:0], miso};
                        end
                    end
                end
                ST_HELD: begin
                    if (take) begin
                        sh     <= tx_data;
                        keep   <= tx_keep;
                        bitcnt <= '0;
                        state  <= ST_SHIFT;
                    end
                end
                ST_TAIL: begin
                    if (cnt == hold_dly) begin
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + DLY_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Received byte: captured with the final sampled bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else begin
            rx_valid <= word_done && !soft_rst;
            if (word_done) begin
                rx_byte <= {sh[DATA_W-2:0], miso};
            end
        end
    end

    assign bit_run = (state == ST_SHIFT);
    assign cs_act  = (state != ST_IDLE);
    assign mosi    = cs_act && sh[DATA_W-1];

endmodule

// File: rtl/spi_cs_hold_master.sv
// Top: SPI master with per-word chip-select hold and programmable delays.
// Assumes one slave select line; the select is active low.
module spi_cs_hold_master #(
    parameter int DATA_W = 8,
    parameter int PRE_W  = 8,
    parameter int DLY_W  = 8,
    parameter int REG_W  = PRE_W + 2 * DLY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic             cs_n
);

    logic              run_en, soft_rst, cs_idle;
    logic [PRE_W-1:0]  prescale;
    logic [DLY_W-1:0]  setup_dly, hold_dly;
    logic [DATA_W-1:0] tx_data, rx_byte;
    logic              tx_keep, tx_full, take, rx_valid, rx_empty;
    logic              bit_run, bit_end, sclk_hi, cs_act;

    spi_chm_regs #(
        .DATA_W(DATA_W), .PRE_W(PRE_W), .DLY_W(DLY_W), .REG_W(REG_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .run_en(run_en), .soft_rst(soft_rst), .cs_idle(cs_idle),
        .prescale(prescale), .setup_dly(setup_dly), .hold_dly(hold_dly),
        .tx_data(tx_data), .tx_keep(tx_keep), .tx_full(tx_full),
        .take(take), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_empty(rx_empty)
    );

    spi_chm_bittimer #(.PRE_W(PRE_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(bit_run), .prescale(prescale),
        .sclk_hi(sclk_hi), .bit_end(bit_end)
    );

    spi_chm_engine #(.DATA_W(DATA_W), .DLY_W(DLY_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .run_en(run_en),
        .setup_dly(setup_dly), .hold_dly(hold_dly), .tx_data(tx_data),
        .tx_keep(tx_keep), .tx_full(tx_full), .take(take),
        .bit_run(bit_run), .bit_end(bit_end), .miso(miso),
        .cs_act(cs_act), .mosi(mosi), .rx_valid(rx_valid),
        .rx_byte(rx_byte)
    );

    assign sclk = sclk_hi;
    assign cs_n = cs_act ? 1'b0 : cs_idle;

endmodule

// File: rtl/spi_chm_checker.sv
// Checker: temporal properties of the SPI master, bound to the top module.
// Assumes it observes internal handshake signals through the bind.
module spi_chm_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk,
    input logic              cs_act,
    input logic              tx_full,
    input logic [DATA_W-1:0] tx_data,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [1:0]        reg_addr,
    input logic              rx_valid,
    input logic              rx_empty,
    input logic              soft_rst,
    input logic              run_en
);

    // R4
    sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> cs_act);

    // R9
    full_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2 && tx_full) |=> $stable(tx_data));

    // R10
    new_byte_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !soft_rst) |=> !rx_empty);

    // R10
    read_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd3 && !rx_valid) |=> rx_empty);

    // R2
    soft_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!tx_full && !cs_act));

    // R3
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !cs_act) |=> !cs_act);

endmodule

bind spi_cs_hold_master spi_chm_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_act(cs_act),
    .tx_full(tx_full), .tx_data(tx_data), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .rx_valid(rx_valid), .rx_empty(rx_empty),
    .soft_rst(soft_rst), .run_en(run_en)
);

// File: tb/tb_spi_cs_hold_master.sv
// Scoreboard bench: driver pushes expected mosi bytes, monitor compares them.
module tb_spi_cs_hold_master;

    localparam int REG_W = 24;
    localparam int TCLK  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic             reg_rd = 1'b0;
    logic [1:0]       reg_addr = 2'd0;
    logic [REG_W-1:0] reg_wdata = '0;
    logic [REG_W-1:0] reg_rdata;
    logic             sclk, mosi, cs_n;
    logic             miso;

    spi_cs_hold_master dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #(TCLK / 2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int k);
        return 8'(k * 37 + 90);
    endfunction

    // Slave model: shifts its reply out on falling edges.
    int         widx = 0;
    int         s_bits = 0;
    logic [7:0] sreg = 8'h00;
    assign miso = sreg[7];

    always @(negedge cs_n) begin
        sreg = pat(widx);
        s_bits = 0;
    end

    always @(negedge sclk) begin
        s_bits++;
        if (s_bits == 8) begin
            s_bits = 0;
            widx++;
            sreg = pat(widx);
        end else begin
            sreg = {sreg[6:0], 1'b0};
        end
    end

    // Monitor: collects mosi bytes and edge timing.
    logic [7:0] mosi_q[$];
    int         m_bits = 0;
    int         mosi_cnt = 0;
    logic [7:0] m_byte = 8'h00;
    longint     t_last_rise = 0, t_last_fall = 0, t_cs_fall = 0;
    longint     t_first_rise = 0, t_cs_rise = 0, gap_ns = 0, period_ns = 0;
    bit         first_pending = 1'b0;
    int         cs_rises = 0;

    always @(posedge sclk) begin
        if (first_pending) begin
            t_first_rise = $time;
            first_pending = 1'b0;
        end else if (m_bits == 0) begin
            gap_ns = $time - t_last_fall;
        end else begin
            period_ns = $time - t_last_rise;
        end
        t_last_rise = $time;
        m_byte = {m_byte[6:0], mosi};
        m_bits++;
        if (m_bits == 8) begin
            m_bits = 0;
            mosi_cnt++;
            if (mosi_q.size() == 0) begin
                chk("R4 unexpected mosi byte", longint'(m_byte), -1);
            end else begin
                chk("R4 mosi byte", longint'(m_byte), longint'(mosi_q.pop_front()));
            end
        end
    end

    always @(negedge sclk) t_last_fall = $time;

    always @(negedge cs_n) begin
        t_cs_fall = $time;
        first_pending = 1'b1;
    end

    always @(posedge cs_n) begin
        t_cs_rise = $time;
        cs_rises++;
    end

    task automatic bus_write(input logic [1:0] a, input logic [REG_W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(output logic [REG_W-1:0] d);
        @(negedge clk);
        reg_rd = 1'b1;
        reg_addr = 2'd3;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Driver: write a word and push its expected mosi byte.
    task automatic send(input logic [7:0] data, input logic keep);
        mosi_q.push_back(data);
        bus_write(2'd2, REG_W'({keep, data}));
    endtask

    task automatic wait_bytes(input int n);
        while (mosi_cnt < n) @(posedge clk);
    endtask

    task automatic wait_cs_high();
        while (cs_n !== 1'b1) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    function automatic logic [REG_W-1:0] timing(input int p, input int s, input int h);
        return {8'(h), 8'(s), 8'(p)};
    endfunction

    logic [REG_W-1:0] rd;
    int               got;
    logic [7:0]       got_byte;

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cs_n", cs_n, 1);
        chk("R1 sclk", sclk, 0);
        bus_read(rd);
        chk("R1 status", rd[9:8], 2'b01);

        // R2 writes ignored while soft reset is set (its reset value)
        bus_write(2'd2, 24'h0000A5);
        bus_read(rd);
        chk("R2 write ignored in soft reset", rd[9], 0);

        // R3 pending word waits for run-enable
        bus_write(2'd0, 24'h000004);
        bus_write(2'd1, timing(3, 2, 1));
        send(8'hC3, 1'b0);
        bus_read(rd);
        chk("R9 tx_full after write", rd[9], 1);
        repeat (40) @(posedge clk);
        #1;
        chk("R3 cs idle while disabled", cs_n, 1);
        bus_write(2'd2, 24'h00005A);       // R9 ignored: buffer full
        bus_write(2'd0, 24'h000005);
        wait_bytes(1);
        wait_cs_high();
        chk("R6 setup time", (t_first_rise - t_cs_fall) / TCLK, 2 + 1 + 2);
        chk("R5 period P=3", period_ns / TCLK, 4);
        chk("R7 tail time", (t_cs_rise - t_last_fall) / TCLK, 1 + 1);
        bus_read(rd);
        chk("R4 rx byte", rd[7:0], pat(0));
        chk("R10 rx not empty", rd[8], 0);
        bus_read(rd);
        chk("R10 read consumes", rd[8], 1);
        repeat (60) @(posedge clk);
        chk("R9 ignored word not sent", mosi_cnt, 1);

        // R8 chained words under keep-select
        bus_write(2'd1, timing(4, 0, 3));
        cs_rises = 0;
        send(8'h81, 1'b1);
        send(8'h7E, 1'b0);
        wait_bytes(3);
        wait_cs_high();
        chk("R8 chained gap", gap_ns / TCLK, 2);
        chk("R8 single frame", cs_rises, 1);
        chk("R6 setup S=0", (t_first_rise - t_cs_fall) / TCLK, 0 + 1 + 2);
        chk("R5 period P=4", period_ns / TCLK, 5);
        chk("R7 tail H=3", (t_cs_rise - t_last_fall) / TCLK, 4);
        bus_read(rd);
        chk("R10 overwrite keeps newest", rd[7:0], pat(2));

        // R8 held select with nothing pending
        cs_rises = 0;
        send(8'h3C, 1'b1);
        wait_bytes(4);
        repeat (100) @(posedge clk);
        #1;
        chk("R8 cs held low", cs_n, 0);
        chk("R8 sclk idle while held", sclk, 0);
        send(8'hE7, 1'b0);
        wait_bytes(5);
        wait_cs_high();
        chk("R8 held frame closes once", cs_rises, 1);

        // R10 completion coinciding with a read
        bus_read(rd);
        send(8'h96, 1'b0);
        got = 0;
        got_byte = 8'h00;
        @(negedge clk);
        reg_rd = 1'b1;
        reg_addr = 2'd3;
        while (cs_n !== 1'b1 || mosi_cnt < 6) begin
            #1;
            if (reg_rdata[8] == 1'b0) begin
                got++;
                got_byte = reg_rdata[7:0];
            end
            @(negedge clk);
        end
        repeat (6) begin
            #1;
            if (reg_rdata[8] == 1'b0) begin
                got++;
                got_byte = reg_rdata[7:0];
            end
            @(negedge clk);
        end
        reg_rd = 1'b0;
        chk("R10 byte seen once under constant reads", got, 1);
        chk("R10 collided byte value", got_byte, pat(5));

        // R11 idle chip-select level
        bus_write(2'd0, 24'h000001);
        repeat (2) @(negedge clk);
        chk("R11 idle level 0", cs_n, 0);
        bus_write(2'd0, 24'h000005);
        repeat (2) @(negedge clk);
        chk("R11 idle level 1", cs_n, 1);

        // R2 soft reset drops a pending word
        bus_write(2'd0, 24'h000004);
        bus_write(2'd2, 24'h000011);
        bus_write(2'd0, 24'h000006);
        bus_read(rd);
        chk("R2 pending dropped", rd[9], 0);
        bus_write(2'd0, 24'h000005);
        repeat (80) @(posedge clk);
        chk("R2 dropped word not sent", mosi_cnt, 6);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * TCLK);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule